// File: doc/BRIEF.md
# Multi-Channel Inter-Processor Mailbox

This block lets several processors pass short messages to each other through a set of independent mailbox channels. Each channel sits in its own 64-byte register window. A sender takes a free channel by writing its one-hot processor ID into the channel's owner register. It then reads that register back: if its own ID comes back, it holds the channel. The sender fills the message words and triggers delivery by writing its ID to the trigger register. Every processor that is not masked, other than the sender, then receives an interrupt. When the message has been answered, the sender clears its answer interrupt and frees the channel by writing its ID to the owner register once more.

Each channel shows its progress as a one-hot state nibble in bits [7:4] of its control register: 0x1 free, 0x2 held, 0x4 delivered, 0x8 answered. Bit 0 of the same register selects self-answer, in which the channel answers on its own one cycle after delivery. The answer-enable masks and the control bits can only be changed after the unlock key has been written to a global key register. A per-processor status word shows which channels are currently interrupting that processor. Each processor's interrupt line is the OR of the channel bits in its status word.

Top module: `ipc_mbx`

## Requirements
- R1: After reset every channel is free: its control register reads 0x10 and its owner register reads 0. All interrupt lines and status words are 0, and the key register (byte offset 0xA00) reads 0, which means locked.
- R2: A free channel is taken when a value with exactly one bit set among bits [NUM_SRC-1:0], and all other bits zero, is written to its owner register (window offset 0x00). The owner register then reads that value and the control state nibble reads 0x2. Any other value is ignored.
- R3: On a channel that is not free, an owner-register write that does not carry the current owner's ID leaves the owner and the state unchanged.
- R4: Writing 0x1ACCE551 to the key register unlocks it, so that it reads 1. Writing any other value locks it, so that it reads 0. While the key register is locked, writes to a channel's control register (offset 0x10) and answer-mask register (offset 0x14) are ignored.
- R5: Message words at offsets 0x20+4k, for k below DATA_WORDS, take writes only while the channel is held (state 0x2). They can be read in any state.
- R6: A write to the flag-set register (offset 0x04) ORs its value into a 32-bit flag word. A write to the flag-clear register (offset 0x08) clears the bits set in its value. The flag word reads at offset 0x0C.
- R7: When the owner writes its ID to the trigger register (offset 0x1C) of a held channel, the state becomes 0x4. The channel then interrupts every processor p with mask bit p clear, except the owner. A trigger write with any other ID leaves a held channel unchanged.
- R8: With control bit 0 set, a delivered channel moves to state 0x8 one clock later and interrupts the owner if the owner's mask bit is clear. The receivers' interrupts stay raised until each receiver writes its own ID to the interrupt-clear register (offset 0x18).
- R9: With control bit 0 clear, a receiver whose interrupt is raised answers a delivered channel by writing its ID to the trigger register. The state then becomes 0x8, all receiver interrupts drop, and the owner is interrupted if its mask bit is clear.
- R10: The owner writing its ID to the interrupt-clear register of an answered channel drops the owner's interrupt. The state stays at 0x8.
- R11: The owner writing its ID to the owner register of a channel that is not free releases the channel. The state returns to 0x1, the owner register reads 0, all of the channel's interrupts drop, and control bit 0 keeps its value.
- R12: The status word for processor p (byte offset 0x800 + 8p) has bit c set exactly when channel c interrupts processor p. Interrupt line p is set when any channel interrupts p.
- R13: Channels are independent: activity in one channel leaves the state of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | NUM_SRC | One interrupt line per processor |

## Verification
A register write takes effect at the rising edge that samples it. Reads and interrupt lines are combinational from the registers. Every result of a write is therefore due right after that edge. The only exception is self-answer, which reaches state 0x8 one edge later. The bench drives each write for one cycle from a falling edge and samples one nanosecond after the following falling edge. For self-answer it checks the delivered state first and then waits exactly one more cycle before checking for the answered state.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;

   localparam int unsigned REG_W = 32;

   // one-hot channel progress, shown in control bits [7:4]
   typedef enum logic [3:0] {
      ST_FREE = 4'h1,
      ST_HELD = 4'h2,
      ST_SENT = 4'h4,
      ST_DONE = 4'h8
   } chan_state_e;

   // word index inside a 64-byte channel window
   localparam logic [3:0] IDX_OWNER = 4'd0;
   localparam logic [3:0] IDX_FSET  = 4'd1;
   localparam logic [3:0] IDX_FCLR  = 4'd2;
   localparam logic [3:0] IDX_FSTAT = 4'd3;
   localparam logic [3:0] IDX_CTRL  = 4'd4;
   localparam logic [3:0] IDX_MASK  = 4'd5;
   localparam logic [3:0] IDX_ICLR  = 4'd6;
   localparam logic [3:0] IDX_TRIG  = 4'd7;
   localparam int unsigned IDX_MSG0 = 8;

   localparam logic [REG_W-1:0] OPEN_KEY = 32'h1ACC_E551;

endpackage

// File: rtl/ipc_mbx_keylock.sv
module ipc_mbx_keylock
   import ipc_mbx_pkg::*;
#(
   parameter logic [REG_W-1:0] KEY = OPEN_KEY
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   output logic             unlocked
);

   logic open_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         open_q <= 1'b0;
      else if (wr)
         open_q <= (wdata == KEY);
   end

   assign unlocked = open_q;

   p_key_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wdata == KEY) |=> unlocked);

   p_other_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wdata != KEY) |=> !unlocked);

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(unlocked));

endmodule

// File: rtl/ipc_mbx_channel.sv
module ipc_mbx_channel
   import ipc_mbx_pkg::*;
#(
   parameter int unsigned NUM_SRC    = 4,
   parameter int unsigned ID_W       = 6,
   parameter int unsigned DATA_WORDS = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               unlocked,
   input  logic               wr_en,
   input  logic [3:0]         wr_idx,
   input  logic [REG_W-1:0]   wdata,
   input  logic [3:0]         rd_idx,
   output logic [REG_W-1:0]   rdata,
   output logic [NUM_SRC-1:0] irq
);

   localparam int unsigned HI_W = REG_W - NUM_SRC;

   chan_state_e        state_q, state_d;
   logic [NUM_SRC-1:0] owner_q, owner_d;
   logic [NUM_SRC-1:0] irq_q, irq_d;
   logic [ID_W-1:0]    mask_q, mask_d;
   logic               self_q, self_d;
   logic [REG_W-1:0]   flag_q, flag_d;
   logic [REG_W-1:0]   msg_q [DATA_WORDS];

   logic [NUM_SRC-1:0] wid;
   logic [NUM_SRC-1:0] open_lines;
   logic               id_ok;
   logic               by_owner;

   assign wid        = wdata[NUM_SRC-1:0];
   assign id_ok      = (wdata[REG_W-1:NUM_SRC] == '0) && $onehot(wid);
   assign by_owner   = id_ok && (state_q != ST_FREE) && (wid == owner_q);
   assign open_lines = ~mask_q[NUM_SRC-1:0];

   always_comb begin
      state_d = state_q;
      owner_d = owner_q;
      irq_d   = irq_q;
      mask_d  = mask_q;
      self_d  = self_q;
      flag_d  = flag_q;

      // self-answer one cycle after delivery
      if (state_q == ST_SENT && self_q) begin
         state_d = ST_DONE;
         irq_d   = irq_q | (owner_q & open_lines);
      end

      if (wr_en) begin
         case (wr_idx)
            IDX_OWNER: begin
               if (state_q == ST_FREE && id_ok) begin
                  state_d = ST_HELD;
                  owner_d = wid;
               end else if (by_owner) begin
                  state_d = ST_FREE;
                  owner_d = '0;
                  irq_d   = '0;
               end
            end
            IDX_FSET: flag_d = flag_q | wdata;
            IDX_FCLR: flag_d = flag_q & ~wdata;
            IDX_CTRL: if (unlocked) self_d = wdata[0];
            IDX_MASK: if (unlocked) mask_d = wdata[ID_W-1:0];
            IDX_ICLR: begin
               if (by_owner && state_q == ST_DONE)
                  irq_d = irq_d & ~owner_q;
               else if (id_ok && state_q != ST_FREE && !by_owner)
                  irq_d = irq_d & ~wid;
            end
            IDX_TRIG: begin
               if (by_owner && state_q == ST_HELD) begin
                  state_d = ST_SENT;
                  irq_d   = open_lines & ~owner_q;
               end else if (state_q == ST_SENT && !self_q && id_ok &&
                            !by_owner && ((wid & irq_q) != '0)) begin
                  state_d = ST_DONE;
                  irq_d   = owner_q & open_lines;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_FREE;
         owner_q <= '0;
         irq_q   <= '0;
         mask_q  <= '0;
         self_q  <= 1'b0;
         flag_q  <= '0;
      end else begin
         state_q <= state_d;
         owner_q <= owner_d;
         irq_q   <= irq_d;
         mask_q  <= mask_d;
         self_q  <= self_d;
         flag_q  <= flag_d;
      end
   end

   for (genvar k = 0; k < DATA_WORDS; k++) begin : g_msg
      always_ff @(posedge clk) begin
         if (!rst_n)
            msg_q[k] <= '0;
         else if (wr_en && wr_idx == 4'(IDX_MSG0 + k) && state_q == ST_HELD)
            msg_q[k] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      case (rd_idx)
         IDX_OWNER: rdata = {{HI_W{1'b0}}, owner_q};
         IDX_FSTAT: rdata = flag_q;
         IDX_CTRL:  rdata = {{(REG_W-8){1'b0}}, state_q, 3'b000, self_q};
         IDX_MASK:  rdata = {{(REG_W-ID_W){1'b0}}, mask_q};
         default: begin
            for (int k = 0; k < DATA_WORDS; k++)
               if (rd_idx == 4'(IDX_MSG0 + k)) rdata = msg_q[k];
         end
      endcase
   end

   assign irq = irq_q;

   p_owner_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_FREE) |-> $onehot(owner_q));

   p_owner_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_FREE) |=> (state_q == ST_FREE) || $stable(owner_q));

   p_locked_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !unlocked && wr_idx == IDX_MASK) |=> $stable(mask_q));

   p_sent_from_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_q == ST_SENT) |-> $past(state_q) == ST_HELD);

   p_self_answer_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SENT && self_q && !wr_en) |=> state_q == ST_DONE);

   p_free_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FREE) |-> (irq_q == '0 && owner_q == '0));

endmodule

// File: rtl/ipc_mbx_irq_map.sv
module ipc_mbx_irq_map #(
   parameter int unsigned NUM_CH  = 4,
   parameter int unsigned NUM_SRC = 4
) (
   input  logic [NUM_CH*NUM_SRC-1:0] ch_irq,
   output logic [NUM_SRC*NUM_CH-1:0] status,
   output logic [NUM_SRC-1:0]        irq_out
);

   for (genvar p = 0; p < NUM_SRC; p++) begin : g_proc
      for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
         assign status[p*NUM_CH + c] = ch_irq[c*NUM_SRC + p];
      end
      assign irq_out[p] = |status[p*NUM_CH +: NUM_CH];
   end

endmodule

// File: rtl/ipc_mbx.sv
module ipc_mbx
   import ipc_mbx_pkg::*;
#(
   parameter int unsigned NUM_CH     = 4,
   parameter int unsigned NUM_SRC    = 4,
   parameter int unsigned ID_W       = 6,
   parameter int unsigned DATA_WORDS = 8,
   parameter int unsigned ADDR_W     = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [REG_W-1:0]   bus_wdata,
   output logic [REG_W-1:0]   bus_rdata,
   output logic [NUM_SRC-1:0] irq_out
);

   localparam logic [9:0] KEY_WORD = 10'h280;  // byte 0xA00

   if (NUM_CH < 1 || NUM_CH > 32) begin : g_bad_ch
      $error("NUM_CH must lie in 1..32");
   end
   if (NUM_SRC < 1 || NUM_SRC > ID_W || ID_W > 8) begin : g_bad_src
      $error("NUM_SRC must lie in 1..ID_W and ID_W may not exceed 8");
   end
   if (DATA_WORDS < 1 || DATA_WORDS > 8) begin : g_bad_msg
      $error("DATA_WORDS must lie in 1..8");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("ADDR_W must be at least 12");
   end

   logic [ADDR_W-1:0] hi_part;
   logic              hi_zero;
   logic              win_hit;
   logic              stat_hit;
   logic              key_hit;
   logic [4:0]        ch_sel;
   logic [4:0]        stat_sel;
   logic [3:0]        idx;
   logic              unlocked;
   logic              unused_addr;

   assign hi_part     = bus_addr >> 12;
   assign hi_zero     = (hi_part == '0);
   assign win_hit     = hi_zero && !bus_addr[11];
   assign stat_hit    = hi_zero && (bus_addr[11:8] == 4'h8) && !bus_addr[2];
   assign key_hit     = hi_zero && (bus_addr[11:2] == KEY_WORD);
   assign ch_sel      = bus_addr[10:6];
   assign stat_sel    = bus_addr[7:3];
   assign idx         = bus_addr[5:2];
   assign unused_addr = ^bus_addr[1:0];

   ipc_mbx_keylock #(.KEY(OPEN_KEY)) u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (bus_wr && key_hit),
      .wdata    (bus_wdata),
      .unlocked (unlocked)
   );

   logic [REG_W-1:0]          ch_rdata [NUM_CH];
   logic [NUM_CH*NUM_SRC-1:0] ch_irq;
   logic [NUM_SRC*NUM_CH-1:0] status;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      ipc_mbx_channel #(
         .NUM_SRC    (NUM_SRC),
         .ID_W       (ID_W),
         .DATA_WORDS (DATA_WORDS)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .unlocked (unlocked),
         .wr_en    (bus_wr && win_hit && ch_sel == 5'(c)),
         .wr_idx   (idx),
         .wdata    (bus_wdata),
         .rd_idx   (idx),
         .rdata    (ch_rdata[c]),
         .irq      (ch_irq[c*NUM_SRC +: NUM_SRC])
      );
   end

   ipc_mbx_irq_map #(.NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC)) u_map (
      .ch_irq  (ch_irq),
      .status  (status),
      .irq_out (irq_out)
   );

   always_comb begin
      bus_rdata = '0;
      if (key_hit)
         bus_rdata = {{(REG_W-1){1'b0}}, unlocked};
      for (int c = 0; c < NUM_CH; c++)
         if (win_hit && ch_sel == 5'(c)) bus_rdata = ch_rdata[c];
      for (int p = 0; p < NUM_SRC; p++)
         if (stat_hit && stat_sel == 5'(p))
            bus_rdata = {{(REG_W-NUM_CH){1'b0}}, status[p*NUM_CH +: NUM_CH]};
   end

endmodule

// File: tb/ipc_mbx_test.sv
module ipc_mbx_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  irq;

   int n_cmp = 0;
   int n_bad = 0;
   logic last_self [4];

   always #10 clk = ~clk;  // 50 MHz

   ipc_mbx uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (addr),
      .bus_wr    (wr),
      .bus_wdata (wdata),
      .bus_rdata (rdata),
      .irq_out   (irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic put(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic get(input logic [11:0] a, output logic [31:0] d);
      addr = a; wr = 1'b0;
      #1;
      d = rdata;
   endtask

   task automatic chk_rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] v;
      get(a, v);
      chk(tag, v, exp);
   endtask

   function automatic logic [11:0] cb(input int c);
      return 12'(c << 6);
   endfunction

   function automatic logic [31:0] pat(input int c, input int s, input int mi, input int k);
      return 32'hA500_0000 | 32'(c << 16) | 32'(s << 12) | 32'(mi << 8) | 32'(k);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] masks [3];
      masks[0] = 32'h00; masks[1] = 32'h05; masks[2] = 32'h0A;
      for (int c = 0; c < 4; c++) last_self[c] = 1'b0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int c = 0; c < 4; c++) begin
         chk_rd("R1 control", cb(c) + 12'h10, 32'h10);
         chk_rd("R1 owner", cb(c), 32'h0);
      end
      for (int p = 0; p < 4; p++) chk_rd("R1 status", 12'h800 + 12'(8*p), 32'h0);
      chk_rd("R1 key", 12'hA00, 32'h0);
      chk("R1 irq", 32'(irq), 32'h0);

      // R4 lock behaviour
      put(cb(0) + 12'h14, 32'h3F);
      chk_rd("R4 mask locked", cb(0) + 12'h14, 32'h0);
      put(cb(0) + 12'h10, 32'h1);
      chk_rd("R4 ctrl locked", cb(0) + 12'h10, 32'h10);
      put(12'hA00, 32'h1ACC_E550);
      chk_rd("R4 wrong key", 12'hA00, 32'h0);
      put(12'hA00, 32'h1ACC_E551);
      chk_rd("R4 key opens", 12'hA00, 32'h1);
      put(cb(0) + 12'h14, 32'h3F);
      chk_rd("R4 mask open", cb(0) + 12'h14, 32'h3F);
      put(12'hA00, 32'h0);
      chk_rd("R4 relock", 12'hA00, 32'h0);
      put(cb(0) + 12'h14, 32'h0);
      chk_rd("R4 mask held", cb(0) + 12'h14, 32'h3F);
      put(12'hA00, 32'h1ACC_E551);
      put(cb(0) + 12'h14, 32'h0);
      chk_rd("R4 mask reopen", cb(0) + 12'h14, 32'h0);

      // R2 invalid IDs
      put(cb(0), 32'h3);
      chk_rd("R2 two bits", cb(0), 32'h0);
      put(cb(0), 32'h10);
      chk_rd("R2 beyond sources", cb(0), 32'h0);
      put(cb(0), 32'h20);
      chk_rd("R2 beyond field", cb(0) + 12'h10, 32'h10);

      // R6 flag word
      put(cb(2) + 12'h04, 32'h05);
      put(cb(2) + 12'h04, 32'h30);
      chk_rd("R6 set", cb(2) + 12'h0C, 32'h35);
      put(cb(2) + 12'h08, 32'h11);
      chk_rd("R6 clear", cb(2) + 12'h0C, 32'h24);
      put(cb(2) + 12'h08, 32'h24);
      chk_rd("R6 empty", cb(2) + 12'h0C, 32'h0);

      // R5 message word while free
      put(cb(3) + 12'h20, 32'h1234);
      chk_rd("R5 free write", cb(3) + 12'h20, 32'h0);

      // full sweep: channel x sender x mask
      for (int c = 0; c < 4; c++) begin
         for (int s = 0; s < 4; s++) begin
            for (int mi = 0; mi < 3; mi++) begin
               logic [31:0] own, oth, m, dest, oirq;
               logic        a;
               int          nb, d;
               own  = 32'(1 << s);
               oth  = 32'(1 << ((s + 1) % 4));
               m    = masks[mi];
               a    = 1'((c + s + mi) % 2);
               dest = ~m & ~own & 32'hF;
               oirq = own & ~m & 32'hF;
               nb   = (c + 1) % 4;

               put(cb(c), own);
               chk_rd("R2 claim owner", cb(c), own);
               chk_rd("R2 claim state", cb(c) + 12'h10, 32'h20 | 32'(last_self[c]));
               put(cb(c), oth);
               chk_rd("R3 foreign claim", cb(c), own);
               put(cb(c) + 12'h10, 32'(a));
               put(cb(c) + 12'h14, m);
               chk_rd("R4 mask", cb(c) + 12'h14, m);
               chk_rd("R4 ctrl", cb(c) + 12'h10, 32'h20 | 32'(a));
               chk_rd("R13 neighbour", cb(nb) + 12'h10, 32'h10 | 32'(last_self[nb]));

               for (int k = 0; k < 8; k++) put(cb(c) + 12'(32 + 4*k), pat(c, s, mi, k));
               for (int k = 0; k < 8; k++)
                  chk_rd("R5 message", cb(c) + 12'(32 + 4*k), pat(c, s, mi, k));

               put(cb(c) + 12'h1C, oth);
               chk_rd("R7 foreign trigger", cb(c) + 12'h10, 32'h20 | 32'(a));
               put(cb(c) + 12'h1C, own);
               chk("R7 receivers", 32'(irq), dest);
               chk_rd("R7 sent state", cb(c) + 12'h10, 32'h40 | 32'(a));
               for (int p = 0; p < 4; p++)
                  chk_rd("R12 status", 12'h800 + 12'(8*p), 32'(dest[p]) << c);

               if (a) begin
                  @(negedge clk);
                  chk_rd("R8 self answer", cb(c) + 12'h10, 32'h81);
                  chk("R8 lines", 32'(irq), dest | oirq);
                  for (int p = 0; p < 4; p++)
                     if (dest[p]) put(cb(c) + 12'h18, 32'(1 << p));
                  chk("R8 receivers cleared", 32'(irq), oirq);
               end else begin
                  d = 0;
                  while (!dest[d]) d++;
                  put(cb(c) + 12'h1C, 32'(1 << d));
                  chk_rd("R9 answered", cb(c) + 12'h10, 32'h80);
                  chk("R9 lines", 32'(irq), oirq);
               end

               put(cb(c) + 12'h18, own);
               chk("R10 owner cleared", 32'(irq), 32'h0);
               chk_rd("R10 state", cb(c) + 12'h10, 32'h80 | 32'(a));

               put(cb(c), own);
               chk_rd("R11 released", cb(c) + 12'h10, 32'h10 | 32'(a));
               chk_rd("R11 owner", cb(c), 32'h0);
               put(cb(c) + 12'h20, 32'h0);
               chk_rd("R5 after release", cb(c) + 12'h20, pat(c, s, mi, 0));
               last_self[c] = a;
            end
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule